// File: doc/BRIEF.md
# Reset-Time Option Loader with Indirect Trim Access

This block gathers device configuration from flash when the chip comes out of reset. Once its reset input is released, it runs a 6-bit counter through a fixed sweep of flash reads, one per clock. The first reads take the user option bytes from the start of program memory and the rest take bytes from the information page. Each returned byte lands in a slot of an option bank. The rest of the chip is held in reset until the last byte has landed and the load-done flag rises.

After loading, the configuration slots below the trim region appear on a wide output bus for the chip's other blocks. The 32 trim bytes are reached only through two registers on a small register bus. Software writes an index into the trim address register. Later accesses to the trim data register then read or replace the working copy of that byte. Software changes live only in the working copy, and flash is never written. A later reset reloads everything from flash.

Top module: `optload_trim`

## Requirements
- R1: After reset is released the block issues exactly 43 flash reads on consecutive clocks, with counter values 0 through 42 in order, and then stops reading. `load_done` rises after the 44th rising edge following release and stays high. `core_hold` is high until `load_done` rises.
- R2: During every read, `flash_addr` carries the counter value in its low 6 bits and zero in every higher bit.
- R3: `flash_info` is 0 (program memory) for counter values 0 and 1 and 1 (information page) for every later read.
- R4: The flash port has one cycle of latency. The byte on `flash_rdata` in the cycle after a read is stored in the slot equal to that read's counter value. Slots 0 to 31 appear on `opt_bytes`, with slot s at bits [8s+7:8s].
- R5: Trim index i (0 to 31) selects slot 20h+i. Slots that the sweep never reaches (2Bh to 3Fh) read 00h after a load.
- R6: A bus write with `bus_sel`=0 and a value below 20h stores that value as the trim index and marks it valid. A read with `bus_sel`=0 returns the valid flag in bit 7, zeros in bits 6:5 and the index in bits 4:0.
- R7: A bus write with `bus_sel`=1 while the index is valid replaces the working copy of the indexed trim byte, and no flash read is issued.
- R8: A bus read with `bus_sel`=1 returns, on `bus_rdata` after the next rising edge, the current working value of the indexed byte. `bus_rdata` holds its value until the next read.
- R9: A `bus_sel`=0 write of 20h or above clears the valid flag and leaves the index unchanged. While the flag is clear, data reads return 00h and data writes change nothing.
- R10: Bus writes made before `load_done` rises are ignored, and bus reads made before then return 00h.
- R11: Reset reloads every slot from flash, discarding software changes, and clears the trim index to 0 with the flag invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; the load sweep starts when it falls |
| flash_rd | output | 1 | Flash read strobe, one read per clock during the sweep |
| flash_addr | output | 12 | Flash byte address; only the low 6 bits are ever nonzero |
| flash_info | output | 1 | 1 selects the information page, 0 selects program memory |
| flash_rdata | input | 8 | Flash read data, valid one cycle after the read |
| load_done | output | 1 | High once every option byte has been stored |
| core_hold | output | 1 | Holds the rest of the chip in reset while loading |
| opt_bytes | output | 256 | Option slots 0 to 31, slot s at bits [8s+7:8s] |
| bus_wr | input | 1 | Register bus write strobe |
| bus_rd | input | 1 | Register bus read strobe |
| bus_sel | input | 1 | 0 selects the trim address register, 1 the trim data register |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Registered read data, updated one edge after a read |

## Verification
The flash model returns bytes drawn from a new random seed on each reset, so the returned bytes differ between program memory and the information page and between loads. Matching them slot by slot therefore shows that the address, the page select and the one-cycle latency adjustment are all correct. Directed sequences exercise the edge indices 00h and 1Fh, out-of-range indices 20h and FFh, and accesses made during the sweep. A long random mix of index writes (both in and out of range), data writes and data reads is compared against a working-copy model. This mix separates a persistent index from a lost one and an invalid index from a wrapped one. A second reset with new flash contents shows that software changes do not survive a reload.

// File: rtl/optload_pkg.sv
package optload_pkg;
  typedef enum logic {
    REG_TIDX = 1'b0,
    REG_TVAL = 1'b1
  } treg_e;
endpackage

// File: rtl/optload_seq.sv
module optload_seq #(
  parameter int CNT_W      = 6,
  parameter int NUM_READS  = 43,
  parameter int USER_BYTES = 2,
  parameter int FLASH_AW   = 12
) (
  input  logic                clk,
  input  logic                rst,
  output logic                flash_rd,
  output logic [FLASH_AW-1:0] flash_addr,
  output logic                flash_info,
  output logic                lat_vld,
  output logic [CNT_W-1:0]    lat_idx,
  output logic                done
);
  localparam logic [CNT_W:0]   N_RD     = (CNT_W+1)'(NUM_READS);
  localparam logic [CNT_W:0]   N_USER   = (CNT_W+1)'(USER_BYTES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_READS - 1);

  logic [CNT_W:0] cnt;
  logic           issuing;

  assign issuing    = (cnt < N_RD);
  assign flash_rd   = issuing;
  assign flash_addr = {{(FLASH_AW-CNT_W){1'b0}}, cnt[CNT_W-1:0]};
  assign flash_info = (cnt >= N_USER);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      lat_vld <= 1'b0;
      lat_idx <= '0;
      done    <= 1'b0;
    end else begin
      if (issuing) cnt <= cnt + 1'b1;
      lat_vld <= issuing;
      lat_idx <= cnt[CNT_W-1:0];
      if (lat_vld && lat_idx == LAST_IDX) done <= 1'b1;
    end
  end
endmodule

// File: rtl/optload_bank.sv
module optload_bank #(
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 6,
  parameter int TRIM_BASE = 32,
  parameter int TRIM_NUM  = 32,
  localparam int TIDX_W   = $clog2(TRIM_NUM)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ld_we,
  input  logic [CNT_W-1:0]            ld_idx,
  input  logic [DATA_W-1:0]           ld_data,
  input  logic                        sw_we,
  input  logic [TIDX_W-1:0]           sw_idx,
  input  logic [DATA_W-1:0]           sw_data,
  output logic [DATA_W-1:0]           sw_rdata,
  output logic [TRIM_BASE*DATA_W-1:0] cfg_bytes
);
  logic [DATA_W-1:0] trim [TRIM_NUM];

  for (genvar s = 0; s < TRIM_BASE; s++) begin : g_cfg
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst)                                 slot_q <= '0;
      else if (ld_we && ld_idx == CNT_W'(s))   slot_q <= ld_data;
    end
    assign cfg_bytes[s*DATA_W +: DATA_W] = slot_q;
  end

  for (genvar t = 0; t < TRIM_NUM; t++) begin : g_trim
    always_ff @(posedge clk) begin
      if (rst)                                           trim[t] <= '0;
      else if (ld_we && ld_idx == CNT_W'(TRIM_BASE + t)) trim[t] <= ld_data;
      else if (sw_we && sw_idx == TIDX_W'(t))            trim[t] <= sw_data;
    end
  end

  assign sw_rdata = trim[sw_idx];
endmodule

// File: rtl/optload_regs.sv
module optload_regs
  import optload_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TRIM_NUM = 32,
  localparam int TIDX_W  = $clog2(TRIM_NUM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tr_we,
  output logic [TIDX_W-1:0] tr_idx,
  output logic [DATA_W-1:0] tr_wdata,
  input  logic [DATA_W-1:0] tr_rdata
);
  localparam logic [DATA_W-1:0] IDX_LIMIT = DATA_W'(TRIM_NUM);

  logic              tvalid;
  logic [TIDX_W-1:0] taddr;
  logic              idx_wr;
  logic [DATA_W-1:0] idx_view;

  assign idx_wr   = en && bus_wr && (treg_e'(bus_sel) == REG_TIDX);
  assign tr_we    = en && bus_wr && (treg_e'(bus_sel) == REG_TVAL) && tvalid;
  assign tr_idx   = taddr;
  assign tr_wdata = bus_wdata;

  always_comb begin
    idx_view = '0;
    idx_view[DATA_W-1]   = tvalid;
    idx_view[TIDX_W-1:0] = taddr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tvalid <= 1'b0;
      taddr  <= '0;
    end else if (idx_wr) begin
      if (bus_wdata < IDX_LIMIT) begin
        tvalid <= 1'b1;
        taddr  <= bus_wdata[TIDX_W-1:0];
      end else begin
        tvalid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                   bus_rdata <= '0;
    else if (bus_rd) begin
      if (!en)                                 bus_rdata <= '0;
      else if (treg_e'(bus_sel) == REG_TIDX)   bus_rdata <= idx_view;
      else                                     bus_rdata <= tvalid ? tr_rdata : '0;
    end
  end
endmodule

// File: rtl/optload_trim.sv
module optload_trim #(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 6,
  parameter int NUM_READS  = 43,
  parameter int USER_BYTES = 2,
  parameter int TRIM_BASE  = 32,
  parameter int TRIM_NUM   = 32,
  parameter int FLASH_AW   = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  output logic                        flash_rd,
  output logic [FLASH_AW-1:0]         flash_addr,
  output logic                        flash_info,
  input  logic [DATA_W-1:0]           flash_rdata,
  output logic                        load_done,
  output logic                        core_hold,
  output logic [TRIM_BASE*DATA_W-1:0] opt_bytes,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic                        bus_sel,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata
);
  localparam int TIDX_W = $clog2(TRIM_NUM);

  logic              lat_vld;
  logic [CNT_W-1:0]  lat_idx;
  logic              tr_we;
  logic [TIDX_W-1:0] tr_idx;
  logic [DATA_W-1:0] tr_wdata;
  logic [DATA_W-1:0] tr_rdata;

  optload_seq #(
    .CNT_W(CNT_W), .NUM_READS(NUM_READS),
    .USER_BYTES(USER_BYTES), .FLASH_AW(FLASH_AW)
  ) u_seq (
    .clk(clk), .rst(rst),
    .flash_rd(flash_rd), .flash_addr(flash_addr), .flash_info(flash_info),
    .lat_vld(lat_vld), .lat_idx(lat_idx), .done(load_done)
  );

  optload_bank #(
    .DATA_W(DATA_W), .CNT_W(CNT_W),
    .TRIM_BASE(TRIM_BASE), .TRIM_NUM(TRIM_NUM)
  ) u_bank (
    .clk(clk), .rst(rst),
    .ld_we(lat_vld), .ld_idx(lat_idx), .ld_data(flash_rdata),
    .sw_we(tr_we), .sw_idx(tr_idx), .sw_data(tr_wdata),
    .sw_rdata(tr_rdata), .cfg_bytes(opt_bytes)
  );

  optload_regs #(
    .DATA_W(DATA_W), .TRIM_NUM(TRIM_NUM)
  ) u_regs (
    .clk(clk), .rst(rst), .en(load_done),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tr_we(tr_we), .tr_idx(tr_idx), .tr_wdata(tr_wdata), .tr_rdata(tr_rdata)
  );

  assign core_hold = ~load_done;
endmodule

// File: rtl/optload_trim_chk.sv
module optload_trim_chk #(
  parameter int CNT_W      = 6,
  parameter int NUM_READS  = 43,
  parameter int USER_BYTES = 2,
  parameter int FLASH_AW   = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                flash_rd,
  input logic [FLASH_AW-1:0] flash_addr,
  input logic                flash_info,
  input logic                load_done,
  input logic                core_hold
);
  logic [15:0] n_reads;

  always_ff @(posedge clk) begin
    if (rst)           n_reads <= '0;
    else if (flash_rd) n_reads <= n_reads + 1'b1;
  end

  AST_ADDR_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    flash_rd |-> (flash_addr >> CNT_W) == '0); // R2

  AST_USER_PAGE: assert property (@(posedge clk) disable iff (rst)
    (flash_rd && flash_addr < FLASH_AW'(USER_BYTES)) |-> !flash_info); // R3

  AST_INFO_PAGE: assert property (@(posedge clk) disable iff (rst)
    (flash_rd && flash_addr >= FLASH_AW'(USER_BYTES)) |-> flash_info); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (flash_rd && $past(flash_rd) && !$past(rst))
      |-> (flash_addr - $past(flash_addr)) == FLASH_AW'(1)); // R1

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    load_done |=> load_done); // R1

  AST_READ_COUNT: assert property (@(posedge clk) disable iff (rst)
    load_done |-> n_reads == 16'(NUM_READS)); // R1

  AST_QUIET_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_done |-> !flash_rd); // R7

  AST_HOLD_DURING_READ: assert property (@(posedge clk) disable iff (rst)
    flash_rd |-> core_hold); // R1
endmodule

bind optload_trim optload_trim_chk #(
  .CNT_W(CNT_W), .NUM_READS(NUM_READS),
  .USER_BYTES(USER_BYTES), .FLASH_AW(FLASH_AW)
) u_chk (
  .clk(clk), .rst(rst), .flash_rd(flash_rd), .flash_addr(flash_addr),
  .flash_info(flash_info), .load_done(load_done), .core_hold(core_hold)
);

// File: tb/optload_trim_test.sv
module optload_trim_test;
  localparam int CLK_PERIOD = 10;
  localparam int NRD        = 43;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         flash_rd;
  logic [11:0]  flash_addr;
  logic         flash_info;
  logic [7:0]   flash_rdata = 8'h00;
  logic         load_done;
  logic         core_hold;
  logic [255:0] opt_bytes;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic         bus_sel = 1'b0;
  logic [7:0]   bus_wdata = 8'h00;
  logic [7:0]   bus_rdata;

  int  n_cmp = 0;
  int  n_bad = 0;
  logic [7:0] fseed = 8'h00;
  logic [7:0] tref [32];
  bit         ref_valid;
  logic [4:0] ref_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  optload_trim uut (
    .clk(clk), .rst(rst), .flash_rd(flash_rd), .flash_addr(flash_addr),
    .flash_info(flash_info), .flash_rdata(flash_rdata), .load_done(load_done),
    .core_hold(core_hold), .opt_bytes(opt_bytes), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] prog_byte(input logic [11:0] a);
    return (a[7:0] * 8'd29 + 8'd3) ^ fseed;
  endfunction

  function automatic logic [7:0] info_byte(input logic [11:0] a);
    return (a[7:0] * 8'd53 + 8'd7) ^ ~fseed;
  endfunction

  function automatic logic [7:0] trim_flash(input int i);
    return (32 + i < NRD) ? info_byte(12'(32 + i)) : 8'h00;
  endfunction

  // flash model with one cycle of read latency
  always @(posedge clk) begin
    if (flash_rd) flash_rdata <= flash_info ? info_byte(flash_addr) : prog_byte(flash_addr);
    else          flash_rdata <= 8'hEE;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input bit sel, input logic [7:0] v);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = v;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input bit sel, output logic [7:0] v);
    bus_rd = 1'b1; bus_sel = sel;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 200 && !load_done; k++) @(negedge clk);
    chk("R1 load_done reached", int'(load_done), 1);
  endtask

  task automatic check_contents(input string tag);
    logic [7:0] v;
    for (int s = 0; s < 32; s++) begin
      chk({tag, " R4 opt slot"}, int'(opt_bytes[s*8 +: 8]),
          int'((s < 2) ? prog_byte(12'(s)) : info_byte(12'(s))));
    end
    for (int i = 0; i < 32; i++) begin
      bus_write(1'b0, 8'(i));
      bus_read(1'b1, v);
      chk({tag, " R5 trim load"}, int'(v), int'(trim_flash(i)));
      tref[i] = trim_flash(i);
    end
    ref_valid = 1'b1; ref_idx = 5'd31;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] held;
    void'($urandom(32'h5eed_0431));
    fseed = 8'($urandom);
    repeat (3) @(negedge clk);
    // reset state
    chk("R1 reset load_done", int'(load_done), 0);
    chk("R1 reset core_hold", int'(core_hold), 1);
    chk("R11 reset rdata", int'(bus_rdata), 0);

    // episode A: timing of the sweep
    rst = 1'b0;
    #1;
    for (int k = 0; k < 47; k++) begin
      if (k > 0) @(negedge clk);
      chk("R1 read strobe", int'(flash_rd), int'(k < NRD));
      if (k < NRD) begin
        chk("R2 address", int'(flash_addr), k);
        chk("R3 page select", int'(flash_info), int'(k >= 2));
      end
      chk("R1 done timing", int'(load_done), int'(k >= NRD + 1));
      chk("R1 core hold", int'(core_hold), int'(k < NRD + 1));
    end
    check_contents("A");

    // directed register corner cases
    bus_write(1'b0, 8'h00);
    bus_read(1'b0, v);  chk("R6 index 00 readback", int'(v), 8'h80);
    bus_write(1'b0, 8'h1F);
    bus_read(1'b0, v);  chk("R6 index 1F readback", int'(v), 8'h9F);
    bus_write(1'b1, 8'hA5);
    chk("R7 no flash access", int'(flash_rd), 0);
    bus_read(1'b1, v);  chk("R8 data readback", int'(v), 8'hA5);
    held = v;
    bus_write(1'b1, 8'h5A);
    chk("R8 rdata held", int'(bus_rdata), int'(held));
    bus_read(1'b1, v);  chk("R7 overwrite", int'(v), 8'h5A);
    tref[31] = 8'h5A;
    bus_write(1'b0, 8'h20);
    bus_read(1'b0, v);  chk("R9 20h clears valid", int'(v), 8'h1F);
    bus_read(1'b1, v);  chk("R9 invalid read", int'(v), 8'h00);
    bus_write(1'b1, 8'h11);
    bus_write(1'b0, 8'hFF);
    bus_read(1'b0, v);  chk("R9 FFh clears valid", int'(v), 8'h1F);
    bus_write(1'b1, 8'h22);
    bus_write(1'b0, 8'h1F);
    bus_read(1'b1, v);  chk("R9 write ignored", int'(v), 8'h5A);
    bus_write(1'b0, 8'h00);
    bus_read(1'b1, v);  chk("R9 neighbour untouched", int'(v), int'(tref[0]));
    ref_valid = 1'b1; ref_idx = 5'd0;

    // random mix against a working-copy model
    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom_range(0, 2));
      if (op == 0) begin
        logic [7:0] a = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 31));
        bus_write(1'b0, a);
        if (a < 8'd32) begin ref_valid = 1'b1; ref_idx = a[4:0]; end
        else ref_valid = 1'b0;
      end else if (op == 1) begin
        logic [7:0] d = 8'($urandom);
        bus_write(1'b1, d);
        if (ref_valid) tref[ref_idx] = d;
      end else begin
        bus_read(1'b1, v);
        chk("R8 random data read", int'(v), ref_valid ? int'(tref[ref_idx]) : 0);
      end
    end
    for (int i = 0; i < 32; i++) begin
      bus_write(1'b0, 8'(i));
      bus_read(1'b1, v);
      chk("R7 random final sweep", int'(v), int'(tref[i]));
    end

    // episode B: reload with new flash contents, bus touched during load
    fseed = fseed ^ 8'($urandom_range(1, 255));
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    bus_write(1'b0, 8'h05);
    bus_read(1'b0, v);  chk("R10 read during load", int'(v), 0);
    bus_write(1'b1, 8'h77);
    wait_done();
    @(negedge clk);
    bus_read(1'b0, v);  chk("R11 index cleared R10 write ignored", int'(v), 8'h00);
    bus_read(1'b1, v);  chk("R11 invalid after reset", int'(v), 8'h00);
    check_contents("B R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule